// File: doc/BRIEF.md
# Inter-Processor Mailbox Controller

This block lets two processor cores pass short messages to each other through a set of independent mailbox channels. Each channel holds a 31-bit message identifier, a small payload of 32-bit data words and two status flags. Both cores reach the same registers through their own simple register port. A sender fills the payload and then writes the identifier with the top bit set. That write launches the message: hardware marks the channel busy and raises a pending interrupt toward the channel's destination core.

The receiver reads the payload and then clears the flags by writing ones to them. A sender waits for the busy flag to drop before it reuses a channel. A mask register holds one interrupt-mask byte per core and one plain storage byte per core, and each core has a single interrupt line. An aggregate register reports every channel's flags in one read.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset every status flag, identifier and data word is 0, the mask register reads 0xFFFFFFFF, and both interrupt lines are low.
- R2: Data words (word address 8*c+1+k for channel c, word k) and the identifier field (address 8*c) can be written from either port and read back from either port, with one cycle of read latency.
- R3: Writing the control word (address 8*c) with bit 31 set stores bits 30:0 as the identifier and sets status bit 0 (busy) and status bit 1 (pending) of that channel, at status address 8*c+5. Bit 31 of the control word always reads 0.
- R4: Writing the control word with bit 31 clear stores the identifier and leaves the status flags unchanged.
- R5: Writing the status word clears each flag whose written bit is 1. Flags written with 0 keep their value.
- R6: The aggregate register at address 64 returns busy of channel i at bit 2i and pending of channel i at bit 2i+1, with the upper bits 0.
- R7: The mask register at address 65 holds the core A interrupt mask in bits 7:0 and the core B interrupt mask in bits 15:8. A core's interrupt line is high exactly when some channel aimed at that core is pending and its mask bit for that core is 0.
- R8: A channel pends toward only one core, set by the DEST parameter (bit c = 1 sends channel c to core B). Its pending flag never raises the other core's line.
- R9: While a channel is busy, writes to its control and data words are ignored.
- R10: Bits 31:16 of the mask register (the core A and core B halt bytes) are read/write storage and do not affect either interrupt line.
- R11: When both ports write the same register in the same cycle, the core A port's value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_sel | input | 1 | Core A access strobe |
| a_wr | input | 1 | Core A write (1) or read (0) |
| a_addr | input | 7 | Core A word address |
| a_wdata | input | 32 | Core A write data |
| a_rdata | output | 32 | Core A read data, valid one cycle after the read |
| b_sel | input | 1 | Core B access strobe |
| b_wr | input | 1 | Core B write (1) or read (0) |
| b_addr | input | 7 | Core B word address |
| b_wdata | input | 32 | Core B write data |
| b_rdata | output | 32 | Core B read data, valid one cycle after the read |
| irq_a | output | 1 | Interrupt toward core A |
| irq_b | output | 1 | Interrupt toward core B |

## Verification
The assertions assume that the flags move only when a port writes. A cycle with no write on either port must leave busy and pending as they were, so the checker treats any other change as an error. They also assume that the mask register is written only through the ports and is never reset to anything but all ones. The stimulus drives at most one access per port per cycle and holds each access steady across its clock edge. It writes both ports in the same cycle only for the port-priority case, and it never leaves a strobe asserted with a write flag of unknown value.

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int NCH = 8,
  parameter int NW = 4,
  parameter logic [NCH-1:0] DEST = 8'hF0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        a_sel,
  input  logic        a_wr,
  input  logic [6:0]  a_addr,
  input  logic [31:0] a_wdata,
  output logic [31:0] a_rdata,
  input  logic        b_sel,
  input  logic        b_wr,
  input  logic [6:0]  b_addr,
  input  logic [31:0] b_wdata,
  output logic [31:0] b_rdata,
  output logic        irq_a,
  output logic        irq_b
);
  localparam int AW = 7;
  localparam logic [AW-1:0] AGG_ADR = AW'(64);
  localparam logic [AW-1:0] MSK_ADR = AW'(65);

  logic [30:0]    id  [NCH];
  logic [31:0]    dat [NCH][NW];
  logic [NCH-1:0] busy, pend;
  logic [31:0]    mreg;
  logic [31:0]    agg;

  wire wa = a_sel && a_wr;
  wire wb = b_sel && b_wr;

  function automatic logic hit_w(input logic [AW-1:0] ad);
    return (wa && a_addr == ad) || (wb && b_addr == ad);
  endfunction

  function automatic logic [31:0] win_d(input logic [AW-1:0] ad);
    return (wa && a_addr == ad) ? a_wdata : b_wdata;
  endfunction

  always_comb begin
    agg = '0;
    for (int c = 0; c < NCH; c++) begin
      agg[2*c]   = busy[c];
      agg[2*c+1] = pend[c];
    end
  end

  function automatic logic [31:0] rd_val(input logic [AW-1:0] ad);
    logic [31:0] v;
    v = '0;
    if (ad == AGG_ADR) v = agg;
    else if (ad == MSK_ADR) v = mreg;
    else
      for (int c = 0; c < NCH; c++) begin
        if (ad == AW'(c*8)) v = {1'b0, id[c]};
        if (ad == AW'(c*8+5)) v = {30'b0, pend[c], busy[c]};
        for (int k = 0; k < NW; k++)
          if (ad == AW'(c*8+1+k)) v = dat[c][k];
      end
    return v;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= '0;
      pend <= '0;
      mreg <= '1;
      for (int c = 0; c < NCH; c++) begin
        id[c] <= '0;
        for (int k = 0; k < NW; k++) dat[c][k] <= '0;
      end
    end else begin
      if (hit_w(MSK_ADR)) mreg <= win_d(MSK_ADR);
      for (int c = 0; c < NCH; c++) begin
        if (!busy[c]) begin
          for (int k = 0; k < NW; k++)
            if (hit_w(AW'(c*8+1+k))) dat[c][k] <= win_d(AW'(c*8+1+k));
          if (hit_w(AW'(c*8))) id[c] <= win_d(AW'(c*8))[30:0];
        end
        if (!busy[c] && hit_w(AW'(c*8)) && win_d(AW'(c*8))[31]) begin
          busy[c] <= 1'b1;
          pend[c] <= 1'b1;
        end else begin
          if ((wa && a_addr == AW'(c*8+5) && a_wdata[0]) ||
              (wb && b_addr == AW'(c*8+5) && b_wdata[0])) busy[c] <= 1'b0;
          if ((wa && a_addr == AW'(c*8+5) && a_wdata[1]) ||
              (wb && b_addr == AW'(c*8+5) && b_wdata[1])) pend[c] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      if (a_sel && !a_wr) a_rdata <= rd_val(a_addr);
      if (b_sel && !b_wr) b_rdata <= rd_val(b_addr);
    end
  end

  assign irq_a = |(pend & ~mreg[NCH-1:0] & ~DEST);
  assign irq_b = |(pend & ~mreg[8+NCH-1:8] & DEST);
endmodule

module ipc_mailbox_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           a_sel,
  input logic           a_wr,
  input logic           b_sel,
  input logic           b_wr,
  input logic [NCH-1:0] busy,
  input logic [NCH-1:0] pend,
  input logic [31:0]    mreg,
  input logic           irq_a,
  input logic           irq_b
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (busy == '0 && pend == '0));

  // R5
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!(a_sel && a_wr) && !(b_sel && b_wr)) |=> ($stable(busy) && $stable(pend)));

  // R7
  irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (pend == '0) |-> (!irq_a && !irq_b));

  // R7
  mask_a_chk: assert property (@(posedge clk) disable iff (rst)
    (mreg[NCH-1:0] == '1) |-> !irq_a);

  // R7
  mask_b_chk: assert property (@(posedge clk) disable iff (rst)
    (mreg[8+NCH-1:8] == '1) |-> !irq_b);

  // R3
  busy_with_pend_chk: assert property (@(posedge clk) disable iff (rst)
    ((busy & ~$past(busy)) & ~pend) == '0);
endmodule

bind ipc_mailbox ipc_mailbox_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .a_sel(a_sel), .a_wr(a_wr), .b_sel(b_sel), .b_wr(b_wr),
  .busy(busy), .pend(pend), .mreg(mreg), .irq_a(irq_a), .irq_b(irq_b)
);

// File: tb/tb_ipc_mailbox.sv
module tb_ipc_mailbox;
  logic clk = 0, rst = 1;
  logic a_sel = 0, a_wr = 0, b_sel = 0, b_wr = 0;
  logic [6:0] a_addr = 0, b_addr = 0;
  logic [31:0] a_wdata = 0, b_wdata = 0;
  logic [31:0] a_rdata, b_rdata;
  logic irq_a, irq_b;
  int total = 0, bad = 0;
  bit done = 0;

  int q_port[$];
  logic [31:0] q_exp[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  ipc_mailbox dut (.*);

  function automatic logic [6:0] ad(int c, int off);
    return 7'(c*8 + off);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int p, logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    if (p == 0) begin a_sel = 1; a_wr = 1; a_addr = a; a_wdata = d; end
    else begin b_sel = 1; b_wr = 1; b_addr = a; b_wdata = d; end
    @(negedge clk);
    a_sel = 0; a_wr = 0; b_sel = 0; b_wr = 0;
  endtask

  task automatic wr2(logic [6:0] a, logic [31:0] da, logic [31:0] db);
    @(negedge clk);
    a_sel = 1; a_wr = 1; a_addr = a; a_wdata = da;
    b_sel = 1; b_wr = 1; b_addr = a; b_wdata = db;
    @(negedge clk);
    a_sel = 0; a_wr = 0; b_sel = 0; b_wr = 0;
  endtask

  task automatic rd(int p, logic [6:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    q_port.push_back(p); q_exp.push_back(e); q_tag.push_back(tag);
    if (p == 0) begin a_sel = 1; a_wr = 0; a_addr = a; end
    else begin b_sel = 1; b_wr = 0; b_addr = a; end
    @(negedge clk);
    a_sel = 0; b_sel = 0;
  endtask

  task automatic irqs(logic ea, logic eb, string tag);
    @(negedge clk);
    chk({tag, " irq_a"}, {31'b0, irq_a}, {31'b0, ea});
    chk({tag, " irq_b"}, {31'b0, irq_b}, {31'b0, eb});
  endtask

  always @(posedge clk) begin
    if (!rst && ((a_sel && !a_wr) || (b_sel && !b_wr))) begin
      #1;
      if (q_exp.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard empty actual=%h expected=none", a_rdata);
      end else begin
        chk(q_tag[0], q_port[0] == 0 ? a_rdata : b_rdata, q_exp[0]);
        void'(q_port.pop_front()); void'(q_exp.pop_front()); void'(q_tag.pop_front());
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    rd(0, 7'd65, 32'hFFFFFFFF, "R1 mask reset");
    rd(1, 7'd64, 32'h0, "R1 aggregate reset");
    rd(0, ad(4, 5), 32'h0, "R1 status reset");
    rd(1, ad(2, 2), 32'h0, "R1 data reset");
    irqs(0, 0, "R1");
    wr(0, ad(2, 1), 32'h12345678);
    wr(1, ad(2, 4), 32'hCAFEF00D);
    rd(1, ad(2, 1), 32'h12345678, "R2 data A->B");
    rd(0, ad(2, 4), 32'hCAFEF00D, "R2 data B->A");
    wr(0, ad(1, 0), 32'h00000123);
    rd(1, ad(1, 0), 32'h00000123, "R4 id stored");
    rd(0, ad(1, 5), 32'h0, "R4 no status");
    wr(0, 7'd65, 32'hAA000000);
    rd(1, 7'd65, 32'hAA000000, "R10 mask readback");
    irqs(0, 0, "R7 nothing pending");
    wr(0, ad(4, 1), 32'hDEAD0004);
    wr(0, ad(4, 0), 32'h80000055);
    rd(1, ad(4, 0), 32'h00000055, "R3 ctrl bit31 reads 0");
    rd(1, ad(4, 5), 32'h3, "R3 status set");
    rd(0, 7'd64, 32'h300, "R6 aggregate ch4");
    irqs(0, 1, "R8 ch4 to core B");
    wr(0, ad(4, 1), 32'h00001111);
    wr(0, ad(4, 0), 32'h80000077);
    rd(1, ad(4, 1), 32'hDEAD0004, "R9 data locked");
    rd(1, ad(4, 0), 32'h00000055, "R9 ctrl locked");
    wr(1, ad(4, 5), 32'h0);
    rd(1, ad(4, 5), 32'h3, "R5 zero write keeps");
    wr(1, ad(4, 5), 32'h2);
    rd(1, ad(4, 5), 32'h1, "R5 clear pending");
    rd(0, 7'd64, 32'h100, "R6 aggregate busy only");
    irqs(0, 0, "R7 cleared pending");
    wr(1, ad(4, 5), 32'h1);
    rd(1, ad(4, 5), 32'h0, "R5 clear busy");
    wr(1, ad(0, 0), 32'h80000001);
    irqs(1, 0, "R8 ch0 to core A");
    rd(0, 7'd64, 32'h3, "R6 aggregate ch0");
    wr(0, 7'd65, 32'hAA000001);
    irqs(0, 0, "R7 masked");
    wr(0, 7'd65, 32'h33000000);
    irqs(1, 0, "R10 halt bytes no effect");
    rd(0, 7'd65, 32'h33000000, "R10 halt storage");
    wr(0, ad(0, 5), 32'h3);
    irqs(0, 0, "R5 cleared ch0");
    wr2(ad(3, 2), 32'h0000000A, 32'h0000000B);
    rd(1, ad(3, 2), 32'h0000000A, "R11 port A wins");
    repeat (4) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finish");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule